// File: doc/BRIEF.md
# Parallel SCSI Bus Register Interface

This block is the host-facing register file of a narrow (8-bit) parallel SCSI bus controller. A host reaches eight byte-wide addresses through a simple synchronous read/write port. Through these addresses it sets the bus control lines, drives the data byte, programs the expected bus phase and watches the live state of the bus. Several addresses hold one register for reads and a different register for writes.

SCSI lines are active-low and open-drain. For that reason every bus output of the block is a drive enable: a 1 pulls the line to its active level. Every bus input is an "asserted" flag, which reads 1 whenever any device drives the line, this one included. The sampled inputs pass through a multi-stage synchroniser before they reach status bits or interrupt logic.

The block raises an interrupt on four events: a selection aimed at an enabled ID, a parity fault on a latched byte, an unexpected drop of BSY, and the end of a DMA transfer. The data-movement engine and the arbitration sequencer sit outside this block. Here they appear only as mode bits, start pulses and status inputs.

Top module: `scsi_bus_regs`

## Requirements
- R1: After reset, every drive enable, `irq` and every start pulse is 0. Addresses 1, 2 and 3 read 0 while the arbitration and DMA status inputs are 0.
- R2: Address 1 (control) reads back bits 7 and 4..0 as written. Its bit 6 reads `arb_in_prog` and its bit 5 reads `arb_lost`. Address 2 (mode) reads back all 8 bits. Address 3 (phase) reads back bits 3..0, and its bit 7 reads `last_byte_sent`.
- R3: Control bits enable line drivers as follows: bit 7 RST, bit 3 BSY, bit 2 SEL, bit 1 ATN, and bit 4 ACK (ACK only while mode bit 6 is 0). A written control bit 6 (tri-state) turns every drive enable off. A written control bit 5 appears on `diff_en`.
- R4: While mode bit 6 (target) is 1, phase bits drive REQ (bit 3), MSG (bit 2), CD (bit 1) and IO (bit 0). While mode bit 6 is 0, these four drivers are off.
- R5: A read of address 4 returns the synchronised bus lines as {RST, BSY, REQ, MSG, CD, IO, SEL, DBP}, from bit 7 down to bit 0. A read of address 0 returns the synchronised data byte.
- R6: `drv_data` equals the byte last written to address 0 in two cases: while mode bit 0 (arbitrate) is 1, or while control bit 0 is 1 and the phase matches. In every other case `drv_data` is 0, and it is also 0 while tri-state is set.
- R7: A read of address 5 returns {DMA end, DRQ, parity error, IRQ, phase match, busy error, ATN, ACK}, from bit 7 down to bit 0. Phase match is 1 exactly when the synchronised {MSG, CD, IO} equals phase bits 2..0.
- R8: A byte written to address 4 is the selection mask. `irq` is set when BSY is inactive, SEL is active and a data line whose mask bit is 1 is active.
- R9: In initiator mode (mode bit 6 = 0), the synchronised data byte is latched into address 6 when REQ goes from active to inactive. In target mode this happens when ACK goes from active to inactive instead. Transitions of the other strobe leave address 6 unchanged.
- R10: When mode bit 5 is 1, a latched byte whose 8 data bits plus DBP have an even number of ones sets the parity-error flag. That event also sets `irq` if mode bit 4 is 1.
- R11: When mode bit 2 is 1, BSY going from active to inactive sets the busy-error flag and `irq`.
- R12: A host read of address 7 clears `irq`, the parity-error flag and the busy-error flag. A set condition present in the same cycle wins over the clear.
- R13: A write to address 5, 6 or 7 gives a one-cycle pulse on `start_dma_send`, `start_tgt_recv` or `start_ini_recv` respectively. These writes change no register.
- R14: When mode bit 3 is 1, a rising edge on `dma_end` sets `irq`. A level that stays high after the clear does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (side effect on address 7) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| bus_data_in | input | 8 | Data lines asserted |
| bus_dbp_in | input | 1 | Data parity line asserted |
| bus_rst_in | input | 1 | RST asserted |
| bus_bsy_in | input | 1 | BSY asserted |
| bus_req_in | input | 1 | REQ asserted |
| bus_msg_in | input | 1 | MSG asserted |
| bus_cd_in | input | 1 | C/D asserted |
| bus_io_in | input | 1 | I/O asserted |
| bus_sel_in | input | 1 | SEL asserted |
| bus_atn_in | input | 1 | ATN asserted |
| bus_ack_in | input | 1 | ACK asserted |
| arb_in_prog | input | 1 | Arbitration in progress, from sequencer |
| arb_lost | input | 1 | Arbitration lost, from sequencer |
| last_byte_sent | input | 1 | DMA last byte sent |
| dma_end | input | 1 | DMA end of transfer |
| dma_drq | input | 1 | DMA request mirror |
| drv_data | output | 8 | Data line drive enables |
| drv_rst | output | 1 | RST drive enable |
| drv_bsy | output | 1 | BSY drive enable |
| drv_sel | output | 1 | SEL drive enable |
| drv_atn | output | 1 | ATN drive enable |
| drv_ack | output | 1 | ACK drive enable |
| drv_req | output | 1 | REQ drive enable |
| drv_msg | output | 1 | MSG drive enable |
| drv_cd | output | 1 | C/D drive enable |
| drv_io | output | 1 | I/O drive enable |
| diff_en | output | 1 | Differential driver enable |
| ctrl_mode | output | 8 | Mode register contents for the DMA and arbitration engines |
| start_dma_send | output | 1 | Start DMA send pulse |
| start_tgt_recv | output | 1 | Start target receive pulse |
| start_ini_recv | output | 1 | Start initiator receive pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a byte latch that carries a parity fault. It needs a full handshake: the bench must raise the strobe, hold it through the synchroniser, drop it, and keep the data and parity lines stable until the delayed edge detector samples them. The bench models the open-drain bus as a wired OR of its own line values and the block's drive enables. With that model it drives REQ or ACK pulses under a chosen mode and reads the latched byte and the flags afterwards. The same loopback lets the block's own drivers decide phase match, so the data-drive gating is tested against lines the block itself asserts.

// File: rtl/scsi_bus_regs.sv
module scsi_bus_regs #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] bus_data_in,
  input  logic          bus_dbp_in,
  input  logic          bus_rst_in,
  input  logic          bus_bsy_in,
  input  logic          bus_req_in,
  input  logic          bus_msg_in,
  input  logic          bus_cd_in,
  input  logic          bus_io_in,
  input  logic          bus_sel_in,
  input  logic          bus_atn_in,
  input  logic          bus_ack_in,
  input  logic          arb_in_prog,
  input  logic          arb_lost,
  input  logic          last_byte_sent,
  input  logic          dma_end,
  input  logic          dma_drq,
  output logic [DW-1:0] drv_data,
  output logic          drv_rst,
  output logic          drv_bsy,
  output logic          drv_sel,
  output logic          drv_atn,
  output logic          drv_ack,
  output logic          drv_req,
  output logic          drv_msg,
  output logic          drv_cd,
  output logic          drv_io,
  output logic          diff_en,
  output logic [7:0]    ctrl_mode,
  output logic          start_dma_send,
  output logic          start_tgt_recv,
  output logic          start_ini_recv,
  output logic          irq
);

  localparam int NCTL = 10;
  localparam int IW   = DW + NCTL;
  localparam int I_ACK = 0, I_ATN = 1, I_SEL = 2, I_IO = 3, I_CD = 4,
                 I_MSG = 5, I_REQ = 6, I_BSY = 7, I_RST = 8, I_DBP = 9;

  logic [SYNC_STAGES-1:0][IW-1:0] sync_q;
  logic [IW-1:0] bus_vec, bus_s;

  logic [DW-1:0] out_data_q, in_data_q, sel_mask_q;
  logic [7:0]    ctl_q, mode_q;
  logic [3:0]    phase_q;
  logic          tristate_q, diff_q;
  logic          req_prev_q, ack_prev_q, bsy_prev_q, eop_prev_q;
  logic          par_err_q, busy_err_q, irq_q;

  assign bus_vec = {bus_data_in, bus_dbp_in, bus_rst_in, bus_bsy_in, bus_req_in,
                    bus_msg_in, bus_cd_in, bus_io_in, bus_sel_in, bus_atn_in, bus_ack_in};

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= bus_vec;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end
  assign bus_s = sync_q[SYNC_STAGES-1];

  logic [DW-1:0] data_s;
  logic rst_s, bsy_s, req_s, msg_s, cd_s, io_s, sel_s, atn_s, ack_s, dbp_s;
  assign data_s = bus_s[IW-1:NCTL];
  assign dbp_s  = bus_s[I_DBP];
  assign rst_s  = bus_s[I_RST];
  assign bsy_s  = bus_s[I_BSY];
  assign req_s  = bus_s[I_REQ];
  assign msg_s  = bus_s[I_MSG];
  assign cd_s   = bus_s[I_CD];
  assign io_s   = bus_s[I_IO];
  assign sel_s  = bus_s[I_SEL];
  assign atn_s  = bus_s[I_ATN];
  assign ack_s  = bus_s[I_ACK];

  logic tgt_mode, phase_match;
  assign tgt_mode    = mode_q[6];
  assign phase_match = ({msg_s, cd_s, io_s} == phase_q[2:0]);

  logic wr0, wr1, wr2, wr3, wr4, rd7;
  assign wr0 = host_wr && host_addr == 3'd0;
  assign wr1 = host_wr && host_addr == 3'd1;
  assign wr2 = host_wr && host_addr == 3'd2;
  assign wr3 = host_wr && host_addr == 3'd3;
  assign wr4 = host_wr && host_addr == 3'd4;
  assign rd7 = host_rd && host_addr == 3'd7;

  assign start_dma_send = host_wr && host_addr == 3'd5;
  assign start_tgt_recv = host_wr && host_addr == 3'd6;
  assign start_ini_recv = host_wr && host_addr == 3'd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data_q <= '0;
      sel_mask_q <= '0;
      ctl_q      <= '0;
      mode_q     <= '0;
      phase_q    <= '0;
      tristate_q <= 1'b0;
      diff_q     <= 1'b0;
    end else begin
      if (wr0) out_data_q <= host_wdata;
      if (wr1) begin
        ctl_q      <= {host_wdata[7], 2'b00, host_wdata[4:0]};
        tristate_q <= host_wdata[6];
        diff_q     <= host_wdata[5];
      end
      if (wr2) mode_q     <= host_wdata[7:0];
      if (wr3) phase_q    <= host_wdata[3:0];
      if (wr4) sel_mask_q <= host_wdata;
    end
  end

  logic drv_on, data_drive;
  assign drv_on     = !tristate_q;
  assign data_drive = drv_on && (mode_q[0] || (ctl_q[0] && phase_match));

  assign drv_data = data_drive ? out_data_q : '0;
  assign drv_rst  = drv_on && ctl_q[7];
  assign drv_bsy  = drv_on && ctl_q[3];
  assign drv_sel  = drv_on && ctl_q[2];
  assign drv_atn  = drv_on && ctl_q[1];
  assign drv_ack  = drv_on && ctl_q[4] && !tgt_mode;
  assign drv_req  = drv_on && tgt_mode && phase_q[3];
  assign drv_msg  = drv_on && tgt_mode && phase_q[2];
  assign drv_cd   = drv_on && tgt_mode && phase_q[1];
  assign drv_io   = drv_on && tgt_mode && phase_q[0];
  assign diff_en  = diff_q;
  assign ctrl_mode = mode_q;

  logic latch_evt, bad_par, par_evt, busy_evt, eop_evt, sel_evt, set_any;
  assign latch_evt = tgt_mode ? (ack_prev_q && !ack_s) : (req_prev_q && !req_s);
  assign bad_par   = !(^{data_s, dbp_s});
  assign par_evt   = latch_evt && mode_q[5] && bad_par;
  assign busy_evt  = mode_q[2] && bsy_prev_q && !bsy_s;
  assign eop_evt   = mode_q[3] && dma_end && !eop_prev_q;
  assign sel_evt   = !bsy_s && sel_s && |(data_s & sel_mask_q);
  assign set_any   = sel_evt || (par_evt && mode_q[4]) || busy_evt || eop_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      ack_prev_q <= 1'b0;
      bsy_prev_q <= 1'b0;
      eop_prev_q <= 1'b0;
      in_data_q  <= '0;
      par_err_q  <= 1'b0;
      busy_err_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      req_prev_q <= req_s;
      ack_prev_q <= ack_s;
      bsy_prev_q <= bsy_s;
      eop_prev_q <= dma_end;
      if (latch_evt) in_data_q <= data_s;
      if (par_evt)       par_err_q  <= 1'b1;
      else if (rd7)      par_err_q  <= 1'b0;
      if (busy_evt)      busy_err_q <= 1'b1;
      else if (rd7)      busy_err_q <= 1'b0;
      if (set_any)       irq_q      <= 1'b1;
      else if (rd7)      irq_q      <= 1'b0;
    end
  end
  assign irq = irq_q;

  always_comb begin
    case (host_addr)
      3'd0: host_rdata = data_s;
      3'd1: host_rdata = {ctl_q[7], arb_in_prog, arb_lost, ctl_q[4:0]};
      3'd2: host_rdata = mode_q;
      3'd3: host_rdata = {last_byte_sent, 3'b000, phase_q};
      3'd4: host_rdata = {rst_s, bsy_s, req_s, msg_s, cd_s, io_s, sel_s, dbp_s};
      3'd5: host_rdata = {dma_end, dma_drq, par_err_q, irq_q, phase_match,
                          busy_err_q, atn_s, ack_s};
      3'd6: host_rdata = in_data_q;
      default: host_rdata = '0;
    endcase
  end

  AST_TRISTATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_addr == 3'd1 && host_wdata[6]) |->
      (drv_data == '0 && !drv_rst && !drv_bsy && !drv_sel && !drv_atn && !drv_ack)); // R3
  AST_TARGET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_req || drv_msg || drv_cd || drv_io) |-> ctrl_mode[6]); // R4
  AST_DATA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_data != '0) |-> (ctrl_mode[0] || ctl_q[0])); // R6
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_err_q) |-> $past(ctrl_mode[2])); // R11
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd7 && !set_any) |=> !irq); // R12
  AST_START_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (start_dma_send || start_tgt_recv || start_ini_recv) |=>
      ($stable(ctrl_mode) && $stable(ctl_q) && $stable(phase_q))); // R13

endmodule

// File: tb/scsi_bus_regs_bench.sv
module scsi_bus_regs_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [7:0] ext_data = '0;
  logic ext_dbp = 0, ext_rst = 0, ext_bsy = 0, ext_req = 0, ext_msg = 0, ext_cd = 0,
        ext_io = 0, ext_sel = 0, ext_atn = 0, ext_ack = 0;
  logic arb_in_prog = 0, arb_lost = 0, last_byte_sent = 0, dma_end = 0, dma_drq = 0;
  logic [7:0] drv_data, ctrl_mode;
  logic drv_rst, drv_bsy, drv_sel, drv_atn, drv_ack, drv_req, drv_msg, drv_cd, drv_io;
  logic diff_en, start_dma_send, start_tgt_recv, start_ini_recv, irq;

  int checks = 0, errors = 0;

  scsi_bus_regs u_scsi_bus_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_data_in(ext_data | drv_data), .bus_dbp_in(ext_dbp), .bus_rst_in(ext_rst | drv_rst),
    .bus_bsy_in(ext_bsy | drv_bsy), .bus_req_in(ext_req | drv_req),
    .bus_msg_in(ext_msg | drv_msg), .bus_cd_in(ext_cd | drv_cd), .bus_io_in(ext_io | drv_io),
    .bus_sel_in(ext_sel | drv_sel), .bus_atn_in(ext_atn | drv_atn),
    .bus_ack_in(ext_ack | drv_ack),
    .arb_in_prog(arb_in_prog), .arb_lost(arb_lost), .last_byte_sent(last_byte_sent),
    .dma_end(dma_end), .dma_drq(dma_drq),
    .drv_data(drv_data), .drv_rst(drv_rst), .drv_bsy(drv_bsy), .drv_sel(drv_sel),
    .drv_atn(drv_atn), .drv_ack(drv_ack), .drv_req(drv_req), .drv_msg(drv_msg),
    .drv_cd(drv_cd), .drv_io(drv_io), .diff_en(diff_en), .ctrl_mode(ctrl_mode),
    .start_dma_send(start_dma_send), .start_tgt_recv(start_tgt_recv),
    .start_ini_recv(start_ini_recv), .irq(irq));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [7:0] drv_ctl();
    return {drv_rst, 2'b00, drv_ack, drv_bsy, drv_sel, drv_atn, 1'b0};
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 drivers", {drv_ctl(), drv_req, drv_msg, drv_cd, drv_io} == 0 ? 8'h0 : 8'h1, 8'h0);
    chk("R1 drv_data", drv_data, 8'h00);
    chk("R1 irq/starts", {4'b0, irq, start_dma_send, start_tgt_recv, start_ini_recv}, 8'h00);
    rd(3'd1, v); chk("R1 control", v, 8'h00);
    rd(3'd2, v); chk("R1 mode", v, 8'h00);
    rd(3'd3, v); chk("R1 phase", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd2, 8'hB6); rd(3'd2, v); chk("R2 mode readback", v, 8'hB6);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hFA); rd(3'd3, v); chk("R2 phase readback", v, 8'h0A);
    last_byte_sent = 1'b1; rd(3'd3, v); chk("R2 last byte sent", v, 8'h8A);
    last_byte_sent = 1'b0; wr(3'd3, 8'h00);
    arb_in_prog = 1'b1; arb_lost = 1'b1;
    rd(3'd1, v); chk("R2 arbitration flags", v, 8'h60);
    arb_in_prog = 1'b0; arb_lost = 1'b0;
  endtask

  task automatic t_ctrl_drive();
    logic [7:0] v;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hBF);
    chk("R3 control drivers", drv_ctl(), 8'h9E);
    chk("R3 diff enable", {7'b0, diff_en}, 8'h01);
    rd(3'd1, v); chk("R3 control readback", v, 8'h9F);
    settle();
    rd(3'd4, v); chk("R5 status via loopback", v, 8'hC2);
    rd(3'd5, v); chk("R7 bus-status atn ack phase", v, 8'h0B);
    wr(3'd1, 8'hDF);
    chk("R3 tri-state silences", drv_ctl(), 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h40); wr(3'd1, 8'h10);
    chk("R3 ACK blocked in target mode", {7'b0, drv_ack}, 8'h00);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    settle();
  endtask

  task automatic t_target_drive();
    logic [7:0] v;
    wr(3'd3, 8'h0F);
    chk("R4 no phase drive as initiator", {4'b0, drv_req, drv_msg, drv_cd, drv_io}, 8'h00);
    wr(3'd2, 8'h40);
    chk("R4 phase drive as target", {4'b0, drv_req, drv_msg, drv_cd, drv_io}, 8'h0F);
    settle();
    rd(3'd4, v); chk("R5 status REQ MSG CD IO", v, 8'h3C);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    settle();
  endtask

  task automatic t_data_drive();
    logic [7:0] v;
    wr(3'd0, 8'hA5);
    chk("R6 idle no data drive", drv_data, 8'h00);
    wr(3'd2, 8'h01);
    chk("R6 arbitration drives data", drv_data, 8'hA5);
    wr(3'd2, 8'h00); wr(3'd3, 8'h01); wr(3'd1, 8'h01);
    settle();
    chk("R6 phase mismatch blocks data", drv_data, 8'h00);
    rd(3'd5, v); chk("R7 phase mismatch flag", v & 8'h08, 8'h00);
    ext_io = 1'b1; settle();
    chk("R6 phase match drives data", drv_data, 8'hA5);
    rd(3'd5, v); chk("R7 phase match flag", v & 8'h08, 8'h08);
    settle();
    rd(3'd0, v); chk("R5 current data read", v, 8'hA5);
    wr(3'd1, 8'h41);
    chk("R6 tri-state blocks data", drv_data, 8'h00);
    wr(3'd1, 8'h00); wr(3'd3, 8'h00); ext_io = 1'b0;
    settle();
  endtask

  task automatic t_selection();
    logic [7:0] v;
    wr(3'd4, 8'h04);
    ext_sel = 1'b1; ext_data = 8'h02; settle();
    chk("R8 unmasked ID no irq", {7'b0, irq}, 8'h00);
    ext_data = 8'h06; ext_bsy = 1'b1; settle();
    chk("R8 BSY active no irq", {7'b0, irq}, 8'h00);
    ext_bsy = 1'b0; settle();
    chk("R8 selection irq", {7'b0, irq}, 8'h01);
    rd(3'd5, v); chk("R7 irq mirror", v & 8'h10, 8'h10);
    rd(3'd7, v);
    chk("R12 set wins over clear", {7'b0, irq}, 8'h01);
    ext_sel = 1'b0; ext_data = 8'h00; settle();
    rd(3'd7, v);
    chk("R12 irq cleared", {7'b0, irq}, 8'h00);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    ext_data = 8'h5A; ext_dbp = 1'b1;
    ext_req = 1'b1; settle(); ext_req = 1'b0; settle();
    rd(3'd6, v); chk("R9 initiator REQ latch", v, 8'h5A);
    wr(3'd2, 8'h40);
    ext_data = 8'h3C; ext_dbp = 1'b1;
    ext_ack = 1'b1; settle(); ext_ack = 1'b0; settle();
    rd(3'd6, v); chk("R9 target ACK latch", v, 8'h3C);
    ext_data = 8'h11;
    ext_req = 1'b1; settle(); ext_req = 1'b0; settle();
    rd(3'd6, v); chk("R9 REQ ignored in target mode", v, 8'h3C);
    wr(3'd2, 8'h00); ext_data = 8'h00; ext_dbp = 1'b0; settle();
  endtask

  task automatic t_parity();
    logic [7:0] v;
    wr(3'd2, 8'h20);
    ext_data = 8'h03; ext_dbp = 1'b0;
    ext_req = 1'b1; settle(); ext_req = 1'b0; settle();
    rd(3'd5, v); chk("R10 parity flag without irq", v & 8'h30, 8'h20);
    rd(3'd7, v); rd(3'd5, v); chk("R12 parity flag cleared", v & 8'h20, 8'h00);
    wr(3'd2, 8'h30);
    ext_req = 1'b1; settle(); ext_req = 1'b0; settle();
    chk("R10 parity irq", {7'b0, irq}, 8'h01);
    rd(3'd7, v);
    ext_data = 8'h07; ext_dbp = 1'b0;
    ext_req = 1'b1; settle(); ext_req = 1'b0; settle();
    rd(3'd5, v); chk("R10 good parity no flag", v & 8'h30, 8'h00);
    wr(3'd2, 8'h00); ext_data = 8'h00; settle();
  endtask

  task automatic t_busy();
    logic [7:0] v;
    ext_bsy = 1'b1; settle();
    ext_bsy = 1'b0; settle();
    chk("R11 no monitor no irq", {7'b0, irq}, 8'h00);
    ext_bsy = 1'b1; settle();
    wr(3'd2, 8'h04);
    ext_bsy = 1'b0; settle();
    chk("R11 busy loss irq", {7'b0, irq}, 8'h01);
    rd(3'd5, v); chk("R11 busy error flag", v & 8'h04, 8'h04);
    rd(3'd7, v);
    rd(3'd5, v); chk("R12 busy flags cleared", v & 8'h14, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_start();
    logic [7:0] v;
    wr(3'd2, 8'h42); wr(3'd1, 8'h02);
    @(negedge clk); host_addr = 3'd5; host_wdata = 8'hFF; host_wr = 1'b1;
    #1 chk("R13 send pulse", {5'b0, start_dma_send, start_tgt_recv, start_ini_recv}, 8'h04);
    host_addr = 3'd6;
    #1 chk("R13 target receive pulse", {5'b0, start_dma_send, start_tgt_recv, start_ini_recv}, 8'h02);
    host_addr = 3'd7;
    #1 chk("R13 initiator receive pulse", {5'b0, start_dma_send, start_tgt_recv, start_ini_recv}, 8'h01);
    @(negedge clk); host_wr = 1'b0;
    #1 chk("R13 pulse ends", {5'b0, start_dma_send, start_tgt_recv, start_ini_recv}, 8'h00);
    rd(3'd2, v); chk("R13 mode unchanged", v, 8'h42);
    rd(3'd1, v); chk("R13 control unchanged", v, 8'h02);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); settle();
  endtask

  task automatic t_eop();
    logic [7:0] v;
    wr(3'd2, 8'h08);
    @(negedge clk); dma_end = 1'b1;
    @(negedge clk);
    chk("R14 end of DMA irq", {7'b0, irq}, 8'h01);
    rd(3'd5, v); chk("R7 end of DMA flag", v & 8'h80, 8'h80);
    rd(3'd7, v); settle();
    chk("R14 level does not retrigger", {7'b0, irq}, 8'h00);
    dma_end = 1'b0; wr(3'd2, 8'h00);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ctrl_drive();
    t_target_drive();
    t_data_drive();
    t_selection();
    t_latch();
    t_parity();
    t_busy();
    t_start();
    t_eop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule